// File: doc/BRIEF.md
# Signed integer to single-precision converter with lane merge

This block takes a signed two's-complement integer and produces the nearest IEEE-754 single-precision value under a selectable rounding mode. It also reports whether rounding changed the value. The integer is 32 bits wide, or 64 bits when a wide-operand request is made while the wide execution mode is active. The 32-bit result lands in bits 31:0 of a wide vector register. The remaining bits of that vector are filled by one of two merge styles.

In the in-place style, every bit above 31 keeps the value it had in the destination. In the three-operand style, bits 127:32 come from a separate first-source vector and every bit from 128 to the top of the vector is cleared.

Operations enter through a valid/ready handshake. The result leaves through a second valid/ready handshake after a fixed two-stage pipeline. The block can take one operation per cycle while the output side keeps up.

Top module: `int2sp_merge`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after the next rising edge. While `out_valid` is high and `out_ready` is low, `res_vec` and `inexact` hold their values. `in_ready` falls only when both stages are occupied and the output is stalled.
- R2: With `sel64` low, the converted value is the signed integer held in `src_int[31:0]`, and bits 63:32 are disregarded.
- R3: With `sel64` and `mode64` both high, the converted value is the signed 64-bit integer in `src_int`.
- R4: With `sel64` high and `mode64` low, the wide request has no effect and the 32-bit path of R2 is used.
- R5: `rnd_mode` = 2'b00 rounds to the nearest representable value, with ties going to the even significand.
- R6: `rnd_mode` = 2'b01 rounds toward negative infinity, 2'b10 toward positive infinity, and 2'b11 toward zero.
- R7: `inexact` is high exactly when the delivered value differs from the integer. This can only happen for magnitudes of at least 2^24.
- R8: A zero input gives +0.0 (all 32 bits zero) with `inexact` low in every rounding mode. The most negative input gives exactly -2^31 (0xCF000000) or -2^63 (0xDF000000).
- R9: When rounding up carries out of the 24-bit significand, the exponent rises by one and the fraction becomes zero. For example, 0x01FFFFFF in mode 00 gives 0x4C000000.
- R10: With `merge3` low, `res_vec[VEC_W-1:32]` equals `dst_vec[VEC_W-1:32]` as sampled at acceptance.
- R11: With `merge3` high, `res_vec[127:32]` equals `src1_vec[127:32]`, and `res_vec[VEC_W-1:128]` is zero.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_int | input | 64 | Signed integer source |
| sel64 | input | 1 | Request the 64-bit source width |
| mode64 | input | 1 | Wide execution mode active; gates `sel64` |
| rnd_mode | input | 2 | 00 nearest-even, 01 down, 10 up, 11 toward zero |
| merge3 | input | 1 | 0: keep destination upper bits; 1: three-operand merge |
| dst_vec | input | VEC_W | Current destination vector contents |
| src1_vec | input | VEC_W | First-source vector for the three-operand merge |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res_vec | output | VEC_W | Merged result vector |
| inexact | output | 1 | Rounding changed the value |

## Verification
The bench checks every result against a remainder-based rounding model and against hand-derived constants for the corner cases. A wrong internal state shows up in `res_vec` on the very next `out_valid` cycle, two edges after acceptance. A bad leading-zero count or a lost carry shifts the exponent field. A wrong guard or sticky bit flips the last fraction bit or the `inexact` flag only for magnitudes of at least 2^24, so those magnitudes are tested in all four modes. A stage-valid or stall error shows as a lost, duplicated or changed result under back-pressure, or as a wrong `in_ready` in the same cycle.

// File: rtl/int2sp_pkg.sv
package int2sp_pkg;
    localparam int SRC_W    = 64;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int FP_W     = 1 + EXP_W + FRAC_W;
    localparam int EXP_BIAS = 127;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_DOWN      = 2'b01,
        RND_UP        = 2'b10,
        RND_ZERO      = 2'b11
    } rnd_e;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic [EXP_W-1:0]  exp;
        logic [SRC_W-1:0]  norm;
    } norm_t;
endpackage

// File: rtl/int2sp_norm.sv
module int2sp_norm
    import int2sp_pkg::*;
(
    input  logic [SRC_W-1:0] src_i,
    input  logic             use64_i,
    output norm_t            norm_o
);
    localparam int LZ_W = $clog2(SRC_W) + 1;

    logic [SRC_W-1:0] ext_w;
    logic [SRC_W-1:0] mag_w;
    logic [LZ_W-1:0]  lz_w;

    always_comb begin
        ext_w = use64_i ? src_i : {{(SRC_W-32){src_i[31]}}, src_i[31:0]};
        mag_w = ext_w[SRC_W-1] ? (~ext_w + 1'b1) : ext_w;
        lz_w  = LZ_W'(SRC_W);
        for (int i = 0; i < SRC_W; i++) begin
            if (mag_w[i]) lz_w = LZ_W'(SRC_W - 1 - i);
        end
        norm_o.sign = ext_w[SRC_W-1];
        norm_o.zero = (mag_w == '0);
        norm_o.norm = mag_w << lz_w;
        norm_o.exp  = EXP_W'(EXP_BIAS + SRC_W - 1 - int'(lz_w));
    end
endmodule

// File: rtl/int2sp_round.sv
module int2sp_round
    import int2sp_pkg::*;
(
    input  norm_t             norm_i,
    input  rnd_e              rnd_i,
    output logic [FP_W-1:0]   fp_o,
    output logic              inexact_o
);
    localparam int KEEP = FRAC_W + 1;
    localparam int DROP = SRC_W - KEEP;

    logic [KEEP-1:0]  mant_w;
    logic             guard_w;
    logic             rest_w;
    logic             lost_w;
    logic             up_w;
    logic [KEEP:0]    sum_w;
    logic [EXP_W-1:0] exp_w;

    always_comb begin
        mant_w  = norm_i.norm[SRC_W-1 -: KEEP];
        guard_w = norm_i.norm[DROP-1];
        rest_w  = |norm_i.norm[DROP-2:0];
        lost_w  = guard_w | rest_w;
        unique case (rnd_i)
            RND_NEAR_EVEN: up_w = guard_w & (rest_w | mant_w[0]);
            RND_DOWN:      up_w = lost_w & norm_i.sign;
            RND_UP:        up_w = lost_w & ~norm_i.sign;
            default:       up_w = 1'b0;
        endcase
        sum_w = {1'b0, mant_w} + (KEEP+1)'(up_w);
        exp_w = norm_i.exp + EXP_W'(sum_w[KEEP]);
        if (norm_i.zero) begin
            fp_o      = '0;
            inexact_o = 1'b0;
        end else begin
            fp_o      = {norm_i.sign, exp_w, sum_w[FRAC_W-1:0]};
            inexact_o = lost_w;
        end
    end
endmodule

// File: rtl/int2sp_lanes.sv
module int2sp_lanes #(
    parameter int VEC_W = 256
) (
    input  logic             merge3_i,
    input  logic [VEC_W-1:0] dst_i,
    input  logic [VEC_W-1:0] src1_i,
    output logic [VEC_W-33:0] upper_o
);
    generate
        if (VEC_W > 128) begin : g_wide
            always_comb begin
                upper_o = merge3_i ? {{(VEC_W-128){1'b0}}, src1_i[127:32]}
                                   : dst_i[VEC_W-1:32];
            end
        end else begin : g_narrow
            always_comb begin
                upper_o = merge3_i ? src1_i[VEC_W-1:32] : dst_i[VEC_W-1:32];
            end
        end
    endgenerate
endmodule

// File: rtl/int2sp_merge.sv
module int2sp_merge
    import int2sp_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      src_int,
    input  logic             sel64,
    input  logic             mode64,
    input  logic [1:0]       rnd_mode,
    input  logic             merge3,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [VEC_W-1:0] src1_vec,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] res_vec,
    output logic             inexact
);
    localparam int UP_W = VEC_W - FP_W;

    typedef struct packed {
        logic              s1_v;
        norm_t             s1_norm;
        rnd_e              s1_rnd;
        logic [UP_W-1:0]   s1_upper;
        logic              s2_v;
        logic [FP_W-1:0]   s2_fp;
        logic              s2_inx;
        logic [UP_W-1:0]   s2_upper;
    } pipe_t;

    pipe_t st_d, st_q;

    norm_t           norm_w;
    logic [UP_W-1:0] upper_w;
    logic [FP_W-1:0] fp_w;
    logic            inx_w;
    logic            adv2_w;

    int2sp_norm u_norm (
        .src_i   (src_int),
        .use64_i (sel64 & mode64),
        .norm_o  (norm_w)
    );

    int2sp_lanes #(.VEC_W(VEC_W)) u_lanes (
        .merge3_i (merge3),
        .dst_i    (dst_vec),
        .src1_i   (src1_vec),
        .upper_o  (upper_w)
    );

    int2sp_round u_round (
        .norm_i    (st_q.s1_norm),
        .rnd_i     (st_q.s1_rnd),
        .fp_o      (fp_w),
        .inexact_o (inx_w)
    );

    always_comb begin
        st_d     = st_q;
        adv2_w   = ~st_q.s2_v | out_ready;
        in_ready = ~st_q.s1_v | adv2_w;
        if (adv2_w) begin
            st_d.s2_v     = st_q.s1_v;
            st_d.s2_fp    = fp_w;
            st_d.s2_inx   = inx_w;
            st_d.s2_upper = st_q.s1_upper;
        end
        if (in_ready) begin
            st_d.s1_v     = in_valid;
            st_d.s1_norm  = norm_w;
            st_d.s1_rnd   = rnd_e'(rnd_mode);
            st_d.s1_upper = upper_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.s2_v;
    assign res_vec   = {st_q.s2_upper, st_q.s2_fp};
    assign inexact   = st_q.s2_inx;

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res_vec) && $stable(inexact));

    // R1
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready && st_q.s1_v);

    // R8
    zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && res_vec[FP_W-2:0] == '0 |-> !inexact);

    // R7
    inexact_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && inexact |-> res_vec[FP_W-2:FRAC_W] >= EXP_W'(EXP_BIAS + FRAC_W + 1));

    // R9
    norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_v && !st_q.s1_norm.zero |-> st_q.s1_norm.norm[SRC_W-1]);
endmodule

// File: tb/int2sp_merge_tb.sv
`timescale 1ns/1ps
module int2sp_merge_tb;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready;
    logic [63:0]   src_int;
    logic          sel64, mode64, merge3;
    logic [1:0]    rnd_mode;
    logic [VW-1:0] dst_vec, src1_vec, res_vec;
    logic          out_valid, out_ready, inexact;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    int2sp_merge #(.VEC_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_int(src_int), .sel64(sel64), .mode64(mode64), .rnd_mode(rnd_mode),
        .merge3(merge3), .dst_vec(dst_vec), .src1_vec(src1_vec),
        .out_valid(out_valid), .out_ready(out_ready), .res_vec(res_vec),
        .inexact(inexact)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Remainder-based reference: {inexact, fp}
    function automatic logic [32:0] ref_cvt(input logic [63:0] s, input bit w64,
                                            input logic [1:0] rm);
        logic [63:0] v, m, q, rem, half;
        int p, sh;
        bit neg, up;
        v   = w64 ? s : {{32{s[31]}}, s[31:0]};
        neg = v[63];
        m   = neg ? (~v + 64'd1) : v;
        if (m == 64'd0) return 33'd0;
        p = 0;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        if (p <= 23) begin
            q = m << (23 - p); rem = 64'd0; half = 64'd0;
        end else begin
            sh   = p - 23;
            q    = m >> sh;
            rem  = m & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
        end
        case (rm)
            2'b00:   up = (rem > half && rem != 0) || (rem != 0 && rem == half && q[0]);
            2'b01:   up = (rem != 0) && neg;
            2'b10:   up = (rem != 0) && !neg;
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        if (q[24]) begin q = q >> 1; p++; end
        return {rem != 0, neg, 8'(127 + p), q[22:0]};
    endfunction

    task automatic run_one(input logic [63:0] s, input bit s64, input bit m64,
                           input logic [1:0] rm, input bit m3, input string req,
                           output logic [31:0] got_fp, output logic got_inx);
        logic [32:0]   r;
        logic [VW-1:0] exp_v;
        r = ref_cvt(s, s64 && m64, rm);
        if (m3) exp_v = {128'd0, src1_vec[127:32], r[31:0]};
        else    exp_v = {dst_vec[VW-1:32], r[31:0]};
        @(negedge clk);
        src_int = s; sel64 = s64; mode64 = m64; rnd_mode = rm; merge3 = m3;
        in_valid = 1'b1; out_ready = 1'b1;
        chk(in_ready == 1'b1, "R1", "in_ready idle", VW'(in_ready), VW'(1));
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R1", "out_valid one edge after accept", VW'(out_valid), VW'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R1", "out_valid two edges after accept", VW'(out_valid), VW'(1));
        chk(res_vec == exp_v, req, "res_vec", res_vec, exp_v);
        chk(inexact == r[32], req, "inexact (R7)", VW'(inexact), VW'(r[32]));
        got_fp  = res_vec[31:0];
        got_inx = inexact;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; src_int = '0;
        sel64 = 1'b0; mode64 = 1'b0; rnd_mode = 2'b00; merge3 = 1'b0;
        dst_vec = {8{32'hA5A5_0F0F}}; src1_vec = {8{32'h1234_5678}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid in reset", VW'(out_valid), VW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid after reset", VW'(out_valid), VW'(0));
        chk(in_ready == 1'b1, "R12", "in_ready after reset", VW'(in_ready), VW'(1));
    endtask

    task automatic t_basic32();
        logic [31:0] f; logic x;
        run_one(64'd1, 0, 1, 2'b00, 0, "R2", f, x);
        chk(f == 32'h3F80_0000, "R2", "one", VW'(f), VW'(32'h3F80_0000));
        run_one(64'hDEAD_BEEF_FFFF_FFFF, 0, 1, 2'b00, 0, "R2", f, x);
        chk(f == 32'hBF80_0000, "R2", "minus one, upper bits ignored", VW'(f), VW'(32'hBF80_0000));
        run_one(64'd100, 0, 0, 2'b11, 0, "R2", f, x);
        run_one(64'h0000_0000_7FFF_FFFF, 0, 1, 2'b00, 0, "R2", f, x);
        chk(f == 32'h4F00_0000 && x, "R2", "max int rounds to 2^31", VW'(f), VW'(32'h4F00_0000));
    endtask

    task automatic t_wide();
        logic [31:0] f; logic x;
        run_one(64'h0123_4567_89AB_CDEF, 1, 1, 2'b00, 0, "R3", f, x);
        run_one(64'hFEDC_BA98_7654_3211, 1, 1, 2'b01, 0, "R3", f, x);
        run_one(64'h0000_0001_0000_0000, 1, 1, 2'b00, 0, "R3", f, x);
        chk(f == 32'h4F80_0000, "R3", "2^32", VW'(f), VW'(32'h4F80_0000));
    endtask

    task automatic t_ignore_wide();
        logic [31:0] f; logic x;
        run_one(64'h0000_0001_0000_0005, 1, 0, 2'b00, 0, "R4", f, x);
        chk(f == 32'h40A0_0000, "R4", "sel64 without mode64 uses low word", VW'(f), VW'(32'h40A0_0000));
    endtask

    task automatic t_modes();
        logic [31:0] f; logic x;
        logic [63:0] vals [6];
        vals[0] = 64'd16777217;  vals[1] = -64'sd16777219;
        vals[2] = 64'd16777219;  vals[3] = 64'h0000_0000_8000_0001;
        vals[4] = 64'd123456789; vals[5] = -64'sd123456789;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                run_one(vals[k], 1, 1, 2'(m), 0, (m == 0) ? "R5" : "R6", f, x);
            end
        end
        run_one(64'd16777217, 0, 1, 2'b00, 0, "R5", f, x);
        chk(f == 32'h4B80_0000 && x, "R5", "tie to even down", VW'(f), VW'(32'h4B80_0000));
        run_one(64'd16777217, 0, 1, 2'b10, 0, "R6", f, x);
        chk(f == 32'h4B80_0001, "R6", "toward +inf", VW'(f), VW'(32'h4B80_0001));
        run_one(-64'sd16777217, 0, 1, 2'b01, 0, "R6", f, x);
        chk(f == 32'hCB80_0001, "R6", "toward -inf", VW'(f), VW'(32'hCB80_0001));
        run_one(-64'sd16777217, 0, 1, 2'b11, 0, "R6", f, x);
        chk(f == 32'hCB80_0000, "R6", "toward zero", VW'(f), VW'(32'hCB80_0000));
    endtask

    task automatic t_corners();
        logic [31:0] f; logic x;
        for (int m = 0; m < 4; m++) begin
            run_one(64'd0, 1, 1, 2'(m), 0, "R8", f, x);
            chk(f == 32'd0 && !x, "R8", "zero to +0 exact", VW'({x, f}), VW'(0));
        end
        run_one(64'h0000_0000_8000_0000, 0, 1, 2'b11, 0, "R8", f, x);
        chk(f == 32'hCF00_0000 && !x, "R8", "most negative 32-bit", VW'(f), VW'(32'hCF00_0000));
        run_one(64'h8000_0000_0000_0000, 1, 1, 2'b10, 0, "R8", f, x);
        chk(f == 32'hDF00_0000 && !x, "R8", "most negative 64-bit", VW'(f), VW'(32'hDF00_0000));
        run_one(64'h0000_0000_01FF_FFFF, 0, 1, 2'b00, 0, "R9", f, x);
        chk(f == 32'h4C00_0000, "R9", "carry bumps exponent", VW'(f), VW'(32'h4C00_0000));
        run_one(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 2'b10, 0, "R9", f, x);
        chk(f == 32'h5F00_0000, "R9", "64-bit carry", VW'(f), VW'(32'h5F00_0000));
    endtask

    task automatic t_merge();
        logic [31:0] f; logic x;
        dst_vec  = {64'hFFFF_0000_FFFF_0000, 64'h1111_2222_3333_4444,
                    64'h5555_6666_7777_8888, 64'h9999_AAAA_BBBB_CCCC};
        src1_vec = {64'hDDDD_EEEE_FFFF_0001, 64'h0203_0405_0607_0809,
                    64'h0A0B_0C0D_0E0F_1011, 64'h1213_1415_1617_1819};
        run_one(64'd42, 0, 1, 2'b00, 0, "R10", f, x);
        run_one(64'd42, 0, 1, 2'b00, 1, "R11", f, x);
        chk(res_vec[255:128] == '0, "R11", "upper half cleared", VW'(res_vec[255:128]), VW'(0));
    endtask

    task automatic t_backpressure();
        logic [VW-1:0] held;
        logic [32:0]   ra, rb;
        ra = ref_cvt(64'd7, 1'b0, 2'b00);
        rb = ref_cvt(64'd9, 1'b0, 2'b00);
        merge3 = 1'b0; sel64 = 1'b0; mode64 = 1'b1; rnd_mode = 2'b00;
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; src_int = 64'd7;
        @(negedge clk);
        src_int = 64'd9;
        chk(in_ready == 1'b1, "R1", "second accept", VW'(in_ready), VW'(1));
        @(negedge clk);
        src_int = 64'd11;
        chk(in_ready == 1'b0, "R1", "full and stalled", VW'(in_ready), VW'(0));
        chk(out_valid && res_vec[31:0] == ra[31:0], "R1", "first result waiting",
            VW'(res_vec[31:0]), VW'(ra[31:0]));
        held = res_vec;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid && res_vec == held, "R1", "held under stall", res_vec, held);
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid && res_vec[31:0] == rb[31:0], "R1", "second result in order",
            VW'(res_vec[31:0]), VW'(rb[31:0]));
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "pipe drained, no extra result", VW'(out_valid), VW'(0));
    endtask

    initial begin
        t_reset();
        t_basic32();
        t_wide();
        t_ignore_wide();
        t_modes();
        t_corners();
        t_merge();
        t_backpressure();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule